// File: doc/BRIEF.md
# Address Bus Tenure Acquisition Controller

This block decides when a bus master may take the address bus on a split-transaction processor bus. The address and data phases on that bus are arbitrated separately. The internal transfer logic raises a request. The block then asks the arbiter for the bus and checks whether the grant it sees is usable. When it wins, it drives address-busy for the whole address phase and gives back a one-cycle start strobe. When the acknowledge arrives, it gives a one-cycle end strobe. It then releases address-busy in two steps. First it drives the line inactive for one cycle, then it turns its output enable off.

All bus signals are active-high inside the block. A grant is usable when three conditions hold: the grant is high, no other master drives busy, and no valid retry is seen. A retry counts only in the cycle just after an acknowledge seen on the bus. A retry of the block's own tenure makes it request the bus again by itself. This happens even if the internal request has already dropped. A grant that is parked on this master is taken at once, with no request cycle first. A grant that was usable one cycle earlier may still be taken in the cycle it is removed.

The states are IDLE, REQUEST, OWN and RELEASE. The transitions are:
- IDLE to OWN on a pending transfer with an accepted grant.
- IDLE to REQUEST on a pending transfer with no accepted grant.
- REQUEST to OWN when the grant is accepted.
- REQUEST to IDLE when the transfer is cancelled.
- OWN to RELEASE on acknowledge.
- RELEASE to REQUEST on a valid retry, or when a transfer is pending with no grant.
- RELEASE to OWN for a back-to-back tenure.
- RELEASE to IDLE otherwise.

Top module: `abt_tenure_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs `bus_req_o`, `abb_o`, `abb_oe_o`, `tenure_start_o` and `tenure_end_o` are all 0.
- R2: `bus_req_o` is 1 in the same cycle whenever a transfer is pending and no tenure is in progress (IDLE or REQUEST). It is 0 while `abb_o` is driven. A transfer is pending when `xfer_req_i` is high or a retry is outstanding.
- R3: A grant is accepted only if `abb_in_i` is 0 in that cycle. While `abb_in_i` is 1, the block stays in REQUEST.
- R4: `artry_i` has an effect only in the cycle right after a cycle with `aack_i` high. There it blocks acceptance. In any other cycle it is ignored.
- R5: If `bus_grant_i` is already high when `xfer_req_i` rises, the grant is accepted in that same cycle, and `abb_o` is 1 in the next cycle.
- R6: In every OWN cycle, `abb_o` and `abb_oe_o` are both 1, and the grant is not sampled. `tenure_start_o` is 1 only in the first OWN cycle.
- R7: `tenure_end_o` is 1 exactly in an OWN cycle with `aack_i` high.
- R8: In the cycle after the acknowledge, `abb_oe_o` is 1 and `abb_o` is 0. In the cycle after that, `abb_oe_o` is 0 unless a new tenure starts.
- R9: If `xfer_req_i` is low in the cycle a grant would be accepted, no tenure starts.
- R10: If the grant was usable in the previous cycle, ownership is still taken in the cycle the grant falls, provided a transfer is pending and `abb_in_i` is 0.
- R11: A valid retry in the cycle after the block's own acknowledge sends it to REQUEST. It holds `bus_req_o` high until a new grant is accepted, even with `xfer_req_i` low.
- R12: A pending transfer with a usable grant in the RELEASE cycle goes straight into a new OWN tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_req_i | input | 1 | Internal transfer request (level) |
| bus_grant_i | input | 1 | Address bus grant from the arbiter |
| abb_in_i | input | 1 | Address-busy driven by other masters |
| aack_i | input | 1 | Address acknowledge |
| artry_i | input | 1 | Address retry |
| bus_req_o | output | 1 | Address bus request |
| abb_o | output | 1 | Address-busy value driven by this master |
| abb_oe_o | output | 1 | Output enable for address-busy |
| tenure_start_o | output | 1 | One-cycle strobe: address tenure begins |
| tenure_end_o | output | 1 | One-cycle strobe: address tenure acknowledged |

## Verification
The hardest conditions to reach from the ports are the two that depend on the previous cycle: the retry window and the late grant. The retry window is reached in two ways. In one, the bus shows another master's acknowledge while this block is IDLE, and the next cycle raises retry together with a free grant. In the other, retry is raised in the RELEASE cycle of the block's own tenure, after the internal request has dropped. The late grant is reached by parking the grant on the block for one cycle while no transfer is pending. The grant is then removed in the same cycle the request rises. A separate case holds the grant with the request already cancelled.

// File: rtl/abt_pkg.sv
`timescale 1ns/1ps
package abt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_OWN     = 2'd2,
        ST_RELEASE = 2'd3
    } abt_state_e;
endpackage

// File: rtl/abt_grant_qual.sv
`timescale 1ns/1ps
// Grant qualification: opens the retry window and remembers last cycle's usable grant.
module abt_grant_qual (
    input  logic clk,
    input  logic rst,
    input  logic bus_grant_i,
    input  logic abb_in_i,
    input  logic aack_i,
    input  logic artry_i,
    input  logic sampling_i,
    output logic retry_valid_o,
    output logic accept_o
);
    logic aack_q;
    logic qg_q;
    logic qg_now;

    always_comb begin
        retry_valid_o = artry_i & aack_q;
        qg_now        = bus_grant_i & ~abb_in_i & ~retry_valid_o;
        accept_o      = sampling_i & ~abb_in_i & ~retry_valid_o & (bus_grant_i | qg_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aack_q <= 1'b0;
            qg_q   <= 1'b0;
        end else begin
            aack_q <= aack_i;
            qg_q   <= qg_now & sampling_i;
        end
    end
endmodule

// File: rtl/abt_fsm.sv
`timescale 1ns/1ps
// Tenure state machine: request, ownership, two-step busy release.
module abt_fsm
    import abt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xfer_req_i,
    input  logic accept_i,
    input  logic retry_valid_i,
    input  logic aack_i,
    output logic sampling_o,
    output logic bus_req_o,
    output logic abb_o,
    output logic abb_oe_o,
    output logic tenure_start_o,
    output logic tenure_end_o
);
    abt_state_e state, state_nx;
    logic retried_q;
    logic was_own_q;
    logic want;

    assign want = xfer_req_i | retried_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            retried_q <= 1'b0;
            was_own_q <= 1'b0;
        end else begin
            state     <= state_nx;
            was_own_q <= (state == ST_OWN);
            if (state == ST_RELEASE && retry_valid_i)
                retried_q <= 1'b1;
            else if (state == ST_OWN)
                retried_q <= 1'b0;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (want && accept_i)  state_nx = ST_OWN;
                else if (want)         state_nx = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (!want)             state_nx = ST_IDLE;
                else if (accept_i)     state_nx = ST_OWN;
            end
            ST_OWN: begin
                if (aack_i)            state_nx = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (retry_valid_i)         state_nx = ST_REQUEST;
                else if (want && accept_i) state_nx = ST_OWN;
                else if (want)             state_nx = ST_REQUEST;
                else                       state_nx = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        sampling_o     = (state != ST_OWN);
        bus_req_o      = 1'b0;
        abb_o          = 1'b0;
        abb_oe_o       = 1'b0;
        tenure_start_o = 1'b0;
        tenure_end_o   = 1'b0;
        unique case (state)
            ST_IDLE, ST_REQUEST: begin
                bus_req_o = want;
            end
            ST_OWN: begin
                abb_o          = 1'b1;
                abb_oe_o       = 1'b1;
                tenure_start_o = ~was_own_q;
                tenure_end_o   = aack_i;
            end
            ST_RELEASE: begin
                abb_oe_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/abt_tenure_ctl.sv
`timescale 1ns/1ps
module abt_tenure_ctl (
    input  logic clk,
    input  logic rst,
    input  logic xfer_req_i,
    input  logic bus_grant_i,
    input  logic abb_in_i,
    input  logic aack_i,
    input  logic artry_i,
    output logic bus_req_o,
    output logic abb_o,
    output logic abb_oe_o,
    output logic tenure_start_o,
    output logic tenure_end_o
);
    logic sampling;
    logic retry_valid;
    logic accept;

    abt_grant_qual u_qual (
        .clk          (clk),
        .rst          (rst),
        .bus_grant_i  (bus_grant_i),
        .abb_in_i     (abb_in_i),
        .aack_i       (aack_i),
        .artry_i      (artry_i),
        .sampling_i   (sampling),
        .retry_valid_o(retry_valid),
        .accept_o     (accept)
    );

    abt_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .xfer_req_i    (xfer_req_i),
        .accept_i      (accept),
        .retry_valid_i (retry_valid),
        .aack_i        (aack_i),
        .sampling_o    (sampling),
        .bus_req_o     (bus_req_o),
        .abb_o         (abb_o),
        .abb_oe_o      (abb_oe_o),
        .tenure_start_o(tenure_start_o),
        .tenure_end_o  (tenure_end_o)
    );
endmodule

// File: rtl/abt_tenure_chk.sv
`timescale 1ns/1ps
module abt_tenure_chk (
    input logic clk,
    input logic rst,
    input logic abb_in_i,
    input logic aack_i,
    input logic bus_req_o,
    input logic abb_o,
    input logic abb_oe_o,
    input logic tenure_start_o,
    input logic tenure_end_o
);
    AST_OE_COVERS_BUSY: assert property (@(posedge clk) disable iff (rst)
        abb_o |-> abb_oe_o); // R6
    AST_START_NEEDS_FREE_BUS: assert property (@(posedge clk) disable iff (rst)
        tenure_start_o |-> $past(!abb_in_i)); // R3
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (abb_o && !aack_i) |=> abb_o); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tenure_start_o |=> !tenure_start_o); // R6
    AST_END_IN_TENURE: assert property (@(posedge clk) disable iff (rst)
        tenure_end_o |-> (abb_o && aack_i)); // R7
    AST_NEGATE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        tenure_end_o |=> (abb_oe_o && !abb_o)); // R8
    AST_TRISTATE_AFTER_NEGATE: assert property (@(posedge clk) disable iff (rst)
        (abb_oe_o && !abb_o) |=> (!abb_oe_o || abb_o)); // R8
    AST_NO_REQ_IN_TENURE: assert property (@(posedge clk) disable iff (rst)
        abb_o |-> !bus_req_o); // R2
endmodule

bind abt_tenure_ctl abt_tenure_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .abb_in_i      (abb_in_i),
    .aack_i        (aack_i),
    .bus_req_o     (bus_req_o),
    .abb_o         (abb_o),
    .abb_oe_o      (abb_oe_o),
    .tenure_start_o(tenure_start_o),
    .tenure_end_o  (tenure_end_o)
);

// File: tb/abt_tenure_ctl_tb.sv
`timescale 1ns/1ps
module abt_tenure_ctl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xfer_req_i = 1'b0, bus_grant_i = 1'b0, abb_in_i = 1'b0, aack_i = 1'b0, artry_i = 1'b0;
    logic bus_req_o, abb_o, abb_oe_o, tenure_start_o, tenure_end_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    abt_tenure_ctl u_dut (
        .clk(clk), .rst(rst), .xfer_req_i(xfer_req_i), .bus_grant_i(bus_grant_i),
        .abb_in_i(abb_in_i), .aack_i(aack_i), .artry_i(artry_i),
        .bus_req_o(bus_req_o), .abb_o(abb_o), .abb_oe_o(abb_oe_o),
        .tenure_start_o(tenure_start_o), .tenure_end_o(tenure_end_o)
    );

    task automatic chk(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    // Inputs change just after a falling edge; checks run 1 ns later.
    task automatic drive(input logic x, input logic g, input logic b, input logic a, input logic r);
        xfer_req_i = x; bus_grant_i = g; abb_in_i = b; aack_i = a; artry_i = r;
        #1;
    endtask

    task automatic next_cyc();
        @(negedge clk);
    endtask

    // Called in an OWN cycle: acknowledge, one negated-drive cycle, then released.
    task automatic close_tenure(input string tag);
        drive(0, 0, 0, 1, 0);
        chk({tag, " R7 end strobe on ack"}, tenure_end_o, 1'b1);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk({tag, " R8 oe held after ack"}, abb_oe_o, 1'b1);
        chk({tag, " R8 busy driven low"}, abb_o, 1'b0);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk({tag, " R8 oe released"}, abb_oe_o, 1'b0);
        next_cyc();
    endtask

    task automatic t_reset();
        drive(0, 0, 0, 0, 0);
        chk("R1 req in reset", bus_req_o, 1'b0);
        chk("R1 oe in reset", abb_oe_o, 1'b0);
        next_cyc(); rst = 1'b0; drive(0, 0, 0, 0, 0);
        chk("R1 busy after reset", abb_o, 1'b0);
        chk("R1 oe after reset", abb_oe_o, 1'b0);
        chk("R1 start after reset", tenure_start_o, 1'b0);
        chk("R1 end after reset", tenure_end_o, 1'b0);
        next_cyc();
    endtask

    task automatic t_busy_block();
        drive(1, 1, 1, 0, 0);
        chk("R2 request while pending", bus_req_o, 1'b1);
        next_cyc(); drive(1, 1, 1, 0, 0);
        chk("R3 blocked by other busy", abb_o, 1'b0);
        chk("R2 request held", bus_req_o, 1'b1);
        next_cyc(); drive(1, 1, 0, 0, 0);
        chk("R3 still requesting", abb_o, 1'b0);
        next_cyc(); drive(1, 0, 0, 0, 0);
        chk("R6 busy on start", abb_o, 1'b1);
        chk("R6 start strobe", tenure_start_o, 1'b1);
        chk("R2 request off in tenure", bus_req_o, 1'b0);
        next_cyc(); drive(1, 0, 1, 0, 0);
        chk("R6 busy ignores grant", abb_o, 1'b1);
        chk("R6 start one cycle", tenure_start_o, 1'b0);
        chk("R7 no end without ack", tenure_end_o, 1'b0);
        next_cyc(); drive(1, 1, 0, 0, 0);
        chk("R6 oe through tenure", abb_oe_o, 1'b1);
        close_tenure("busy");
    endtask

    task automatic t_parked();
        drive(0, 1, 0, 0, 0);
        chk("R5 no request when idle", bus_req_o, 1'b0);
        next_cyc(); drive(1, 1, 0, 0, 0);
        chk("R5 request seen", bus_req_o, 1'b1);
        next_cyc();
        chk("R5 parked grant taken", abb_o, 1'b1);
        chk("R5 start strobe", tenure_start_o, 1'b1);
        close_tenure("parked");
    endtask

    task automatic t_retry_outside();
        drive(1, 1, 0, 0, 1);
        next_cyc();
        chk("R4 stray retry ignored", abb_o, 1'b1);
        close_tenure("stray");
    endtask

    task automatic t_retry_other_ack();
        drive(0, 0, 0, 1, 0);
        next_cyc(); drive(1, 1, 0, 0, 1);
        next_cyc(); drive(1, 1, 0, 0, 0);
        chk("R4 retry window blocks grant", abb_o, 1'b0);
        chk("R4 still requesting", bus_req_o, 1'b1);
        next_cyc();
        chk("R4 taken after window", abb_o, 1'b1);
        close_tenure("window");
    endtask

    task automatic t_own_retry();
        drive(1, 1, 0, 0, 0);
        next_cyc(); drive(0, 0, 0, 1, 0);
        chk("R11 first tenure", abb_o, 1'b1);
        next_cyc(); drive(0, 1, 0, 0, 1);
        chk("R8 negated on retry cycle", abb_o, 1'b0);
        chk("R8 oe on retry cycle", abb_oe_o, 1'b1);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk("R11 re-request after retry", bus_req_o, 1'b1);
        chk("R11 no tenure in window", abb_o, 1'b0);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk("R11 request held", bus_req_o, 1'b1);
        chk("R11 waiting for grant", abb_o, 1'b0);
        drive(0, 1, 0, 0, 0);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk("R11 retried tenure starts", tenure_start_o, 1'b1);
        close_tenure("retry");
        chk("R11 request cleared after retried tenure", bus_req_o, 1'b0);
    endtask

    task automatic t_cancel();
        drive(1, 0, 0, 0, 0);
        next_cyc(); drive(0, 1, 0, 0, 0);
        chk("R9 request dropped", bus_req_o, 1'b0);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk("R9 no tenure after cancel", abb_o, 1'b0);
        chk("R9 oe off after cancel", abb_oe_o, 1'b0);
        next_cyc();
        chk("R9 still idle", abb_o, 1'b0);
        next_cyc();
    endtask

    task automatic t_late_grant();
        drive(0, 1, 0, 0, 0);
        next_cyc(); drive(1, 0, 0, 0, 0);
        next_cyc();
        chk("R10 taken as grant falls", abb_o, 1'b1);
        chk("R10 start strobe", tenure_start_o, 1'b1);
        close_tenure("late");
        drive(0, 0, 0, 0, 0);
        next_cyc(); drive(1, 0, 0, 0, 0);
        next_cyc();
        chk("R10 stale grant not used", abb_o, 1'b0);
        drive(0, 0, 0, 0, 0);
        next_cyc(); next_cyc();
    endtask

    task automatic t_back_to_back();
        drive(1, 1, 0, 0, 0);
        next_cyc(); drive(1, 1, 0, 1, 0);
        chk("R12 first tenure", abb_o, 1'b1);
        next_cyc(); drive(1, 1, 0, 0, 0);
        chk("R12 release cycle", abb_o, 1'b0);
        next_cyc(); drive(0, 0, 0, 0, 0);
        chk("R12 second tenure busy", abb_o, 1'b1);
        chk("R12 second start", tenure_start_o, 1'b1);
        close_tenure("b2b");
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_busy_block();
        t_parked();
        t_retry_outside();
        t_retry_other_ack();
        t_own_retry();
        t_cancel();
        t_late_grant();
        t_back_to_back();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule